// File: doc/BRIEF.md
# Serial Frame Completion Sequencer

This block is the master-side sequencer of one channel of a serial sensor bus. When the transmit FIFO holds a word, it loads that word and an externally computed check field into a shift register. It drives the frame out most significant bit first, one bit per bit-enable tick, and samples the returning line on the same ticks. After the final check bit it closes the frame in two cycles of their own. The first cycle pushes the received word into the receive FIFO, and the error flag from the CRC checker is latched there. The second cycle pops the sent word from the transmit FIFO. The two strobes never share a cycle.

The sequencer then holds the bus quiet for a programmable minimum gap, so that the remote nodes can refill their storage capacitors. The gap timer is cleared on the edge that ends the last check bit. Because of this, the push and pop cycles count toward the gap rather than extending it. When the gap has run out, the sequencer starts the next frame at once if the transmit FIFO has a word; otherwise it goes idle. Dropping the enable or raising abort sends it back to idle on the next cycle.

Top module: `frame_end_seq`

## Requirements
- R1: After reset, frame_active, rx_push, tx_pop, crc_err and sdo are all 0.
- R2: In idle, with enable high, abort low and tx_empty low, frame_active rises at the next clock edge and sdo then shows bit DATA_W-1 of tx_data.
- R3: A frame is DATA_W bits of tx_data followed by CRC_W bits of tx_crc, most significant bit first. sdo moves to the next bit on each clock edge where bit_tick is high, and sdi is sampled on that same edge. The first DATA_W samples make up rx_word, first sample in the most significant position.
- R4: The clock edge that takes the last check bit ends frame_active. Exactly one cycle of rx_push follows, then exactly one cycle of tx_pop. The two are never high together.
- R5: crc_err takes the value of crc_err_in at the edge that ends the rx_push cycle, holds it, and returns to 0 at the edge where the next frame starts.
- R6: When the transmit FIFO is non-empty after the pop, frame_active rises exactly max(frame_gap, 2) + 1 cycles after the rx_push cycle, counted from that cycle.
- R7: When the transmit FIFO is empty once the gap has elapsed, the sequencer stays idle. It starts a frame one cycle after tx_empty falls.
- R8: enable low or abort high makes frame_active, rx_push and tx_pop all 0 from the next cycle on, with no push or pop for the cut frame. A pending word is sent again from its first bit once the block is re-enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Channel enable |
| abort | input | 1 | Cancel the current activity and return to idle |
| bit_tick | input | 1 | Advance one serial bit |
| tx_empty | input | 1 | Transmit FIFO holds no word |
| tx_data | input | DATA_W | Head word of the transmit FIFO |
| tx_crc | input | CRC_W | Check field for the head word |
| sdi | input | 1 | Serial return line |
| crc_err_in | input | 1 | Error flag from the receive CRC checker |
| frame_gap | input | GAP_W | Minimum inter-frame gap in cycles |
| sdo | output | 1 | Serial output bit |
| frame_active | output | 1 | Frame shifting in progress |
| rx_word | output | DATA_W | Received word, valid with rx_push |
| rx_push | output | 1 | Receive FIFO push strobe |
| tx_pop | output | 1 | Transmit FIFO pop strobe |
| crc_err | output | 1 | Latched error flag of the last frame |

## Verification
A sequencer stuck in or skipping the push or pop state shows up within one cycle of the last bit edge as a missing, doubled or overlapping strobe. A gap counter cleared at the wrong moment shifts the next rise of frame_active by a whole number of cycles, which the bench measures exactly for gap settings below, at and above the two bookkeeping cycles. A wrong shift or bit count corrupts sdo at the first bad tick and rx_word at the push.

// File: rtl/fes_pkg.sv
package fes_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_XFER  = 3'd1,
        ST_RPUSH = 3'd2,
        ST_XPOP  = 3'd3,
        ST_GAP   = 3'd4
    } fes_state_e;
endpackage

// File: rtl/fes_gap_timer.sv
// Saturating up-counter measuring the quiet time between frames.
module fes_gap_timer #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [GAP_W-1:0] limit,
    output logic             done
);
    localparam logic [GAP_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [GAP_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (clr) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt != CNT_MAX) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign done = (tmr_q.cnt >= limit);
endmodule

// File: rtl/fes_shifter.sv
// Frame shift register: sends data then check field MSB first, collects the return line.
module fes_shifter #(
    parameter int DATA_W = 8,
    parameter int CRC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [CRC_W-1:0]  tx_crc,
    input  logic              sdi,
    output logic              sdo,
    output logic              last_bit,
    output logic [DATA_W-1:0] rx_word
);
    localparam int FRAME_W = DATA_W + CRC_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic [FRAME_W-1:0] tx_sh;
        logic [FRAME_W-1:0] rx_sh;
        logic [CNT_W-1:0]   cnt;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.tx_sh = {tx_data, tx_crc};
            sh_d.rx_sh = '0;
            sh_d.cnt   = '0;
        end else if (shift) begin
            sh_d.tx_sh = {sh_q.tx_sh[FRAME_W-2:0], 1'b0};
            sh_d.rx_sh = {sh_q.rx_sh[FRAME_W-2:0], sdi};
            sh_d.cnt   = sh_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sdo      = sh_q.tx_sh[FRAME_W-1];
    assign last_bit = (sh_q.cnt == LAST_IDX);

    // The last CRC_W samples are the check field, which the external checker handles.
    generate
        if (CRC_W > 0) begin : g_with_crc
            assign rx_word = sh_q.rx_sh[FRAME_W-1 -: DATA_W];
        end else begin : g_no_crc
            assign rx_word = sh_q.rx_sh[DATA_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/fes_ctrl.sv
// Frame sequencing state machine and latched error flag.
module fes_ctrl
    import fes_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic abort,
    input  logic tx_empty,
    input  logic bit_tick,
    input  logic last_bit,
    input  logic gap_done,
    input  logic crc_err_in,
    output logic load,
    output logic shift,
    output logic gap_clr,
    output logic frame_active,
    output logic rx_push,
    output logic tx_pop,
    output logic crc_err
);
    typedef struct packed {
        fes_state_e st;
        logic       crc_err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic kill;

    assign kill = !enable || abort;

    always_comb begin
        ctl_d   = ctl_q;
        load    = 1'b0;
        shift   = 1'b0;
        gap_clr = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (!tx_empty) begin
                    ctl_d.st      = ST_XFER;
                    ctl_d.crc_err = 1'b0;
                    load          = 1'b1;
                end
            end
            ST_XFER: begin
                if (bit_tick) begin
                    shift = 1'b1;
                    if (last_bit) begin
                        ctl_d.st = ST_RPUSH;
                        gap_clr  = 1'b1;
                    end
                end
            end
            ST_RPUSH: begin
                ctl_d.crc_err = crc_err_in;
                ctl_d.st      = ST_XPOP;
            end
            ST_XPOP: begin
                ctl_d.st = ST_GAP;
            end
            ST_GAP: begin
                if (gap_done) begin
                    if (!tx_empty) begin
                        ctl_d.st      = ST_XFER;
                        ctl_d.crc_err = 1'b0;
                        load          = 1'b1;
                    end else begin
                        ctl_d.st = ST_IDLE;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
        if (kill) begin
            ctl_d.st = ST_IDLE;
            load     = 1'b0;
            shift    = 1'b0;
            gap_clr  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, crc_err: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign frame_active = (ctl_q.st == ST_XFER);
    assign rx_push      = (ctl_q.st == ST_RPUSH);
    assign tx_pop       = (ctl_q.st == ST_XPOP);
    assign crc_err      = ctl_q.crc_err;
endmodule

// File: rtl/frame_end_seq.sv
module frame_end_seq #(
    parameter int DATA_W = 8,
    parameter int CRC_W  = 4,
    parameter int GAP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              abort,
    input  logic              bit_tick,
    input  logic              tx_empty,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [CRC_W-1:0]  tx_crc,
    input  logic              sdi,
    input  logic              crc_err_in,
    input  logic [GAP_W-1:0]  frame_gap,
    output logic              sdo,
    output logic              frame_active,
    output logic [DATA_W-1:0] rx_word,
    output logic              rx_push,
    output logic              tx_pop,
    output logic              crc_err
);
    logic load, shift, gap_clr, last_bit, gap_done;

    fes_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .abort        (abort),
        .tx_empty     (tx_empty),
        .bit_tick     (bit_tick),
        .last_bit     (last_bit),
        .gap_done     (gap_done),
        .crc_err_in   (crc_err_in),
        .load         (load),
        .shift        (shift),
        .gap_clr      (gap_clr),
        .frame_active (frame_active),
        .rx_push      (rx_push),
        .tx_pop       (tx_pop),
        .crc_err      (crc_err)
    );

    fes_shifter #(
        .DATA_W (DATA_W),
        .CRC_W  (CRC_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .shift    (shift),
        .tx_data  (tx_data),
        .tx_crc   (tx_crc),
        .sdi      (sdi),
        .sdo      (sdo),
        .last_bit (last_bit),
        .rx_word  (rx_word)
    );

    fes_gap_timer #(
        .GAP_W (GAP_W)
    ) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (gap_clr),
        .limit (frame_gap),
        .done  (gap_done)
    );
endmodule

// File: rtl/fes_checker.sv
module fes_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic abort,
    input logic tx_empty,
    input logic frame_active,
    input logic rx_push,
    input logic tx_pop,
    input logic crc_err
);
    assert_push_pop_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_push && tx_pop));

    assert_pop_follows_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && enable && !abort) |=> tx_pop);

    assert_single_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> !rx_push);

    assert_start_needs_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_active) |-> $past(!tx_empty && enable && !abort));

    assert_err_clear_on_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_active) |-> !crc_err);

    assert_err_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rx_push) && !$rose(frame_active)) |-> $stable(crc_err));

    assert_kill_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable || abort) |=> (!frame_active && !rx_push && !tx_pop));
endmodule

bind frame_end_seq fes_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .abort        (abort),
    .tx_empty     (tx_empty),
    .frame_active (frame_active),
    .rx_push      (rx_push),
    .tx_pop       (tx_pop),
    .crc_err      (crc_err)
);

// File: tb/sim_frame_end_seq.sv
module sim_frame_end_seq;
    localparam int DATA_W  = 8;
    localparam int CRC_W   = 4;
    localparam int GAP_W   = 8;
    localparam int FRAME_W = DATA_W + CRC_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enable = 1'b0;
    logic              abort = 1'b0;
    logic              bit_tick = 1'b0;
    logic [DATA_W-1:0] tx_data = '0;
    logic [CRC_W-1:0]  tx_crc = '0;
    logic              sdi = 1'b0;
    logic              crc_err_in = 1'b0;
    logic [GAP_W-1:0]  frame_gap = '0;
    logic              sdo, frame_active, rx_push, tx_pop, crc_err;
    logic [DATA_W-1:0] rx_word;
    logic              tx_empty;

    int pending = 0;
    int total = 0;
    int bad = 0;
    int cyc = 0;

    assign tx_empty = (pending == 0);

    frame_end_seq #(.DATA_W(DATA_W), .CRC_W(CRC_W), .GAP_W(GAP_W)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .abort(abort),
        .bit_tick(bit_tick), .tx_empty(tx_empty), .tx_data(tx_data),
        .tx_crc(tx_crc), .sdi(sdi), .crc_err_in(crc_err_in),
        .frame_gap(frame_gap), .sdo(sdo), .frame_active(frame_active),
        .rx_word(rx_word), .rx_push(rx_push), .tx_pop(tx_pop), .crc_err(crc_err)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog (all requirements) act=%0d exp<=%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wait_active();
        while (!frame_active) step();
    endtask

    // Sends nbits of the current frame; after the final bit the bench sits in the push cycle.
    task automatic send_bits(input logic [DATA_W-1:0] d, input logic [CRC_W-1:0] c,
                             input logic [DATA_W-1:0] rxpat, input int nbits);
        logic [FRAME_W-1:0] fr;
        fr = {d, c};
        for (int i = 0; i < nbits; i++) begin
            check("R3 sdo bit", int'(sdo), int'(fr[FRAME_W-1-i]));
            sdi = (i < DATA_W) ? rxpat[DATA_W-1-i] : i[0];
            bit_tick = 1'b1;
            step();
            bit_tick = 1'b0;
            if (i != FRAME_W - 1) step();
        end
    endtask

    task automatic push_pop(input logic [DATA_W-1:0] rx_exp, input logic crc_exp);
        check("R4 frame ended", int'(frame_active), 0);
        check("R4 push", int'(rx_push), 1);
        check("R4 no pop with push", int'(tx_pop), 0);
        check("R3 rx_word", int'(rx_word), int'(rx_exp));
        step();
        check("R4 pop", int'(tx_pop), 1);
        check("R4 push one cycle", int'(rx_push), 0);
        check("R5 crc latched", int'(crc_err), int'(crc_exp));
        if (tx_pop) pending--;
    endtask

    task automatic t_reset();
        check("R1 frame_active", int'(frame_active), 0);
        check("R1 rx_push", int'(rx_push), 0);
        check("R1 tx_pop", int'(tx_pop), 0);
        check("R1 crc_err", int'(crc_err), 0);
        check("R1 sdo", int'(sdo), 0);
    endtask

    task automatic t_gap(input int g);
        int k;
        int exp_k;
        frame_gap = GAP_W'(g);
        repeat (25) step();
        tx_data = 8'hA5; tx_crc = 4'h9; crc_err_in = 1'b1;
        pending = 2;
        wait_active();
        check("R2 start msb", int'(sdo), 1);
        send_bits(8'hA5, 4'h9, 8'h6B, FRAME_W);
        push_pop(8'h6B, 1'b1);
        tx_data = 8'h3C; tx_crc = 4'h6; crc_err_in = 1'b0;
        k = 1;
        while (!frame_active) begin
            step();
            k++;
        end
        exp_k = ((g > 2) ? g : 2) + 1;
        check("R6 gap length", k, exp_k);
        check("R5 crc cleared at start", int'(crc_err), 0);
        send_bits(8'h3C, 4'h6, 8'hD2, FRAME_W);
        push_pop(8'hD2, 1'b0);
        repeat (g + 8) step();
        check("R7 idle when empty", int'(frame_active), 0);
        tx_data = 8'h81; tx_crc = 4'hF;
        pending = 1;
        step();
        check("R7 start from idle", int'(frame_active), 1);
        send_bits(8'h81, 4'hF, 8'h18, FRAME_W);
        push_pop(8'h18, 1'b0);
    endtask

    task automatic t_kill();
        frame_gap = 8'd4;
        repeat (20) step();
        tx_data = 8'hC3; tx_crc = 4'h5; crc_err_in = 1'b1;
        pending = 1;
        step();
        check("R2 start next cycle", int'(frame_active), 1);
        send_bits(8'hC3, 4'h5, 8'h00, 3);
        abort = 1'b1;
        step();
        check("R8 abort idles", int'(frame_active), 0);
        check("R8 abort no push", int'(rx_push), 0);
        abort = 1'b0;
        step();
        check("R8 restart", int'(frame_active), 1);
        check("R8 restart first bit", int'(sdo), 1);
        enable = 1'b0;
        step();
        check("R8 disable idles", int'(frame_active), 0);
        for (int i = 0; i < 5; i++) begin
            step();
            check("R8 held idle", int'(frame_active || rx_push || tx_pop), 0);
        end
        enable = 1'b1;
        step();
        check("R8 resume", int'(frame_active), 1);
        send_bits(8'hC3, 4'h5, 8'h5A, FRAME_W);
        push_pop(8'h5A, 1'b1);
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        enable = 1'b1;
        step();
        t_reset();
        t_gap(10);
        t_gap(0);
        t_gap(3);
        t_kill();
        repeat (5) step();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule